// File: doc/BRIEF.md
# Drift-Compensated Time Counter

This block keeps a 64-bit time count that advances only on strobes from a slow reference clock, yet tracks the count a much faster nominal oscillator would have reached. Each reference strobe adds a programmed whole-number increment: the oscillator-to-reference rate ratio, rounded to the nearest integer. The rounding error is then removed over time. A programmed signed magnitude, in hundredths of a count per strobe, is summed into a small fractional accumulator. Each time that accumulator crosses one whole count, the count gets one extra step up or down.

Software sets the increment, the compensation word and a run bit through a small write port. It reads the count as two 32-bit words through a registered read port. Reading the lower word captures the upper word at the same instant, so a following upper read belongs to the same sample. The full count is also presented on a parallel output for local consumers in the same clock domain.

Top module: `drift_comp_counter`

## Requirements
- R1: After reset the count, the fractional accumulator, all three configuration registers and `rd_data` are zero, and the count does not move.
- R2: The count and the fractional accumulator change only on a cycle where `ref_tick` is 1 and the run bit is 1. The run bit is bit 0 of the word at address 2. Clearing it freezes both, and setting it again resumes from the frozen values.
- R3: On each advancing strobe the count grows by the unsigned value of the increment register, which is at address 0.
- R4: The compensation word is at address 1. Its bit 31 is the direction and bits 6:0 are the magnitude in hundredths. Each advancing strobe adds the magnitude to the accumulator. When the sum reaches 100, 100 is removed and the count gets one extra step: +1 when bit 31 is 1, -1 when bit 31 is 0.
- R5: A magnitude field above 99 behaves as 99. Bits 30:7 of the compensation word have no effect on the count.
- R6: A write applies from the next clock edge on. A strobe in the same cycle as a write still uses the old register value.
- R7: A read with `rd_en` puts the addressed word on `rd_data` one cycle later. Addresses 0, 1 and 2 return the stored increment, the compensation word and the run bit, an unmapped address returns 0, and `rd_data` holds its value on cycles without `rd_en`.
- R8: A read of address 3 returns bits 31:0 of the count as it was before that cycle's edge, and captures bits 63:32 of that same value. A read of address 4 returns the captured upper word even if the count has since moved.
- R9: The count wraps modulo 2^64 in both directions. A carry or borrow out of the lower word passes into the upper word, and `count_o` shows the full count in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_tick | input | 1 | One-cycle strobe per reference period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |
| count_o | output | 64 | Current count |

## Verification
Two kinds of collision matter here. The first is a write to the increment register in the same cycle as a reference strobe. The bench provokes it and checks that this strobe adds the old increment and the following strobe adds the new one. The second is a lower-word read that falls on a strobe, followed by an upper-word read that also falls on a strobe. The bench judges this pair by whether the two words rebuild the count seen just before the first read. The increment is chosen so that the upper word moves on every strobe, so any live upper read shows up as a mismatch.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

   localparam int unsigned REG_ADDR_W = 3;

   typedef enum logic [REG_ADDR_W-1:0] {
      A_RATE   = 3'd0,
      A_TRIM   = 3'd1,
      A_RUN    = 3'd2,
      A_CNT_LO = 3'd3,
      A_CNT_HI = 3'd4
   } reg_addr_e;

   typedef struct packed {
      logic extra;   // one whole correction count due this strobe
      logic up;      // direction of that count
   } trim_step_t;

endpackage

// File: rtl/dcc_cfg_regs.sv
module dcc_cfg_regs
   import dcc_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  wr_en,
   input  logic [REG_ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0]     wr_data,
   output logic [DATA_W-1:0]     rate_o,
   output logic [DATA_W-1:0]     trim_o,
   output logic                  run_o
);

   always_ff @(posedge clk) begin
      if (rst) begin
         rate_o <= '0;
         trim_o <= '0;
         run_o  <= 1'b0;
      end else if (wr_en) begin
         case (wr_addr)
            A_RATE:  rate_o <= wr_data;
            A_TRIM:  trim_o <= wr_data;
            A_RUN:   run_o  <= wr_data[0];
            default: ;
         endcase
      end
   end

   // R6
   rate_load_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_addr == A_RATE) |=> rate_o == $past(wr_data));

   // R6
   cfg_keep_chk: assert property (@(posedge clk) disable iff (rst)
      !wr_en |=> ($stable(rate_o) && $stable(trim_o) && $stable(run_o)));

endmodule

// File: rtl/dcc_frac_acc.sv
module dcc_frac_acc
   import dcc_pkg::*;
#(
   parameter int unsigned MAG_W     = 7,
   parameter int unsigned FRAC_BASE = 100
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             adv,
   input  logic             trim_up,
   input  logic [MAG_W-1:0] trim_mag,
   output trim_step_t       step_o
);

   localparam int unsigned SUM_W = MAG_W + 1;
   localparam logic [MAG_W-1:0] MAG_MAX = MAG_W'(FRAC_BASE - 1);
   localparam logic [SUM_W-1:0] BASE_V  = SUM_W'(FRAC_BASE);

   generate
      if (FRAC_BASE < 2 || FRAC_BASE > (1 << MAG_W)) begin : g_bad_base
         $error("dcc_frac_acc: FRAC_BASE must fit the magnitude field");
      end
   endgenerate

   logic [MAG_W-1:0] acc_q;
   logic [MAG_W-1:0] mag_eff;
   logic [SUM_W-1:0] sum;
   logic             carry;

   always_comb begin
      mag_eff = (trim_mag > MAG_MAX) ? MAG_MAX : trim_mag;
      sum     = {1'b0, acc_q} + {1'b0, mag_eff};
      carry   = (sum >= BASE_V);
      step_o.extra = adv && carry;
      step_o.up    = trim_up;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q <= '0;
      end else if (adv) begin
         acc_q <= carry ? MAG_W'(sum - BASE_V) : sum[MAG_W-1:0];
      end
   end

   // R4
   acc_range_chk: assert property (@(posedge clk) disable iff (rst)
      acc_q < MAG_W'(FRAC_BASE));

   // R2
   acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !adv |=> $stable(acc_q));

   // R5
   no_carry_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !adv |-> !step_o.extra);

endmodule

// File: rtl/dcc_count.sv
module dcc_count
   import dcc_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W  = 64
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              adv,
   input  logic [DATA_W-1:0] rate,
   input  trim_step_t        step,
   output logic [CNT_W-1:0]  cnt_o
);

   generate
      if (CNT_W <= DATA_W || CNT_W > 2 * DATA_W) begin : g_bad_width
         $error("dcc_count: CNT_W must lie in (DATA_W, 2*DATA_W]");
      end
   endgenerate

   logic [CNT_W-1:0] adj;
   logic [CNT_W-1:0] cnt_n;

   always_comb begin
      if (!step.extra)   adj = '0;
      else if (step.up)  adj = CNT_W'(1);
      else               adj = '1;
      cnt_n = cnt_o + CNT_W'(rate) + adj;
   end

   always_ff @(posedge clk) begin
      if (rst)      cnt_o <= '0;
      else if (adv) cnt_o <= cnt_n;
   end

   // R2
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !adv |=> $stable(cnt_o));

   // R3
   step_size_chk: assert property (@(posedge clk) disable iff (rst)
      adv |=> ((cnt_o - $past(cnt_o) - CNT_W'($past(rate)) + CNT_W'(1)) <= CNT_W'(2)));

   // R4
   trim_applied_chk: assert property (@(posedge clk) disable iff (rst)
      (adv && step.extra) |=> (cnt_o - $past(cnt_o)) != CNT_W'($past(rate)));

endmodule

// File: rtl/dcc_read_port.sv
module dcc_read_port
   import dcc_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned CNT_W   = 64,
   parameter bit          SNAP_HI = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  rd_en,
   input  logic [REG_ADDR_W-1:0] rd_addr,
   input  logic [DATA_W-1:0]     rate,
   input  logic [DATA_W-1:0]     trim,
   input  logic                  run,
   input  logic [CNT_W-1:0]      cnt,
   output logic [DATA_W-1:0]     rd_data
);

   localparam int unsigned HI_W = CNT_W - DATA_W;

   logic [HI_W-1:0] hi_val;

   generate
      if (SNAP_HI) begin : g_snap
         logic [HI_W-1:0] hi_q;
         always_ff @(posedge clk) begin
            if (rst)                              hi_q <= '0;
            else if (rd_en && rd_addr == A_CNT_LO) hi_q <= cnt[CNT_W-1:DATA_W];
         end
         assign hi_val = hi_q;

         // R8
         hi_snap_chk: assert property (@(posedge clk) disable iff (rst)
            (rd_en && rd_addr == A_CNT_LO) |=> hi_q == $past(cnt[CNT_W-1:DATA_W]));
      end else begin : g_live
         assign hi_val = cnt[CNT_W-1:DATA_W];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_data <= '0;
      end else if (rd_en) begin
         case (rd_addr)
            A_RATE:   rd_data <= rate;
            A_TRIM:   rd_data <= trim;
            A_RUN:    rd_data <= DATA_W'(run);
            A_CNT_LO: rd_data <= cnt[DATA_W-1:0];
            A_CNT_HI: rd_data <= DATA_W'(hi_val);
            default:  rd_data <= '0;
         endcase
      end
   end

   // R7
   rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !rd_en |=> $stable(rd_data));

   // R8
   lo_read_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_en && rd_addr == A_CNT_LO) |=> rd_data == $past(cnt[DATA_W-1:0]));

endmodule

// File: rtl/drift_comp_counter.sv
module drift_comp_counter
   import dcc_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned CNT_W     = 64,
   parameter int unsigned MAG_W     = 7,
   parameter int unsigned FRAC_BASE = 100,
   parameter bit          SNAP_HI   = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  ref_tick,
   input  logic                  wr_en,
   input  logic [REG_ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0]     wr_data,
   input  logic                  rd_en,
   input  logic [REG_ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0]     rd_data,
   output logic [CNT_W-1:0]      count_o
);

   localparam int unsigned SIGN_BIT = DATA_W - 1;

   generate
      if (MAG_W >= SIGN_BIT) begin : g_bad_mag
         $error("drift_comp_counter: magnitude field overlaps the sign bit");
      end
   endgenerate

   logic [DATA_W-1:0] rate;
   logic [DATA_W-1:0] trim;
   logic              run;
   logic              adv;
   trim_step_t        step;

   assign adv = ref_tick && run;

   dcc_cfg_regs #(.DATA_W(DATA_W)) u_cfg (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rate_o  (rate),
      .trim_o  (trim),
      .run_o   (run)
   );

   dcc_frac_acc #(.MAG_W(MAG_W), .FRAC_BASE(FRAC_BASE)) u_frac (
      .clk      (clk),
      .rst      (rst),
      .adv      (adv),
      .trim_up  (trim[SIGN_BIT]),
      .trim_mag (trim[MAG_W-1:0]),
      .step_o   (step)
   );

   dcc_count #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .adv   (adv),
      .rate  (rate),
      .step  (step),
      .cnt_o (count_o)
   );

   dcc_read_port #(.DATA_W(DATA_W), .CNT_W(CNT_W), .SNAP_HI(SNAP_HI)) u_rd (
      .clk     (clk),
      .rst     (rst),
      .rd_en   (rd_en),
      .rd_addr (rd_addr),
      .rate    (rate),
      .trim    (trim),
      .run     (run),
      .cnt     (count_o),
      .rd_data (rd_data)
   );

   // R1
   reset_zero_chk: assert property (@(posedge clk)
      rst |=> (count_o == '0 && rd_data == '0));

endmodule

// File: tb/drift_comp_counter_bench.sv
module drift_comp_counter_bench;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        ref_tick = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [2:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic [63:0] count_o;

   always #5 clk = ~clk;

   drift_comp_counter u_drift_comp_counter (
      .clk(clk), .rst(rst), .ref_tick(ref_tick),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .count_o(count_o)
   );

   int    total = 0;
   int    bad   = 0;
   string tag   = "R1";
   bit    live  = 1'b0;

   // behavioural reference model
   longint unsigned m_cnt = 0;
   int              m_acc = 0;
   logic [31:0]     m_rate = 0, m_trim = 0, m_rd = 0, m_hi = 0;
   bit              m_run = 0;

   always @(posedge clk) begin
      int mag;
      live <= 1'b1;
      if (rst) begin
         m_cnt = 0; m_acc = 0; m_rate = 0; m_trim = 0; m_rd = 0; m_hi = 0; m_run = 0;
      end else begin
         if (rd_en) begin
            case (rd_addr)
               3'd0: m_rd = m_rate;
               3'd1: m_rd = m_trim;
               3'd2: m_rd = {31'd0, m_run};
               3'd3: begin m_rd = m_cnt[31:0]; m_hi = m_cnt[63:32]; end
               3'd4: m_rd = m_hi;
               default: m_rd = 0;
            endcase
         end
         if (ref_tick && m_run) begin
            mag = int'(m_trim[6:0]);
            if (mag > 99) mag = 99;
            m_acc = m_acc + mag;
            if (m_acc >= 100) begin
               m_acc = m_acc - 100;
               if (m_trim[31]) m_cnt = m_cnt + 1;
               else            m_cnt = m_cnt - 1;
            end
            m_cnt = m_cnt + longint'(m_rate);
         end
         if (wr_en) begin
            case (wr_addr)
               3'd0: m_rate = wr_data;
               3'd1: m_trim = wr_data;
               3'd2: m_run  = wr_data[0];
               default: ;
            endcase
         end
      end
   end

   task automatic check64(string t, logic [63:0] act, logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", t, act, exp);
      end
   endtask

   // compare against the model on every clock
   always @(negedge clk) begin
      if (live) begin
         check64({tag, " count"}, count_o, m_cnt);
         check64({tag, " rd_data"}, {32'd0, rd_data}, {32'd0, m_rd});
      end
   end

   task automatic cyc(bit t, bit we, logic [2:0] wa, logic [31:0] wd, bit re, logic [2:0] ra);
      @(negedge clk);
      ref_tick = t; wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
   endtask

   task automatic idle();
      cyc(0, 0, 0, 0, 0, 0);
   endtask

   task automatic wr(logic [2:0] a, logic [31:0] d);
      cyc(0, 1, a, d, 0, 0);
   endtask

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) cyc(1, 0, 0, 0, 0, 0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      idle(); idle();
      rst = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [63:0] snap;
      tag = "R1";
      do_reset();
      idle();
      check64("R1 reset count", count_o, 64'd0);
      check64("R1 reset rd_data", {32'd0, rd_data}, 64'd0);

      tag = "R2";
      ticks(5); idle();
      check64("R2 idle without run", count_o, 64'd0);

      tag = "R3";
      wr(3'd0, 32'd5); wr(3'd1, 32'h8000_0019); wr(3'd2, 32'd1);
      cyc(0, 0, 0, 0, 1, 3'd0); idle();
      check64("R7 readback rate", {32'd0, rd_data}, 64'd5);
      ticks(8); idle();
      check64("R3 R4 add with up trim", count_o, 64'd42);

      tag = "R4";
      wr(3'd0, 32'd10); wr(3'd1, 32'h0000_0032);
      ticks(4); idle();
      check64("R4 down trim", count_o, 64'd80);

      tag = "R5";
      wr(3'd0, 32'd3); wr(3'd1, 32'hFFFF_FFFF);
      ticks(100); idle();
      check64("R5 clamped magnitude", count_o, 64'd479);

      tag = "R6";
      wr(3'd1, 32'd0);
      cyc(1, 1, 3'd0, 32'd7, 0, 0);
      cyc(1, 0, 0, 0, 0, 0);
      check64("R6 collision uses old rate", count_o, 64'd482);
      idle();
      check64("R6 new rate next strobe", count_o, 64'd489);

      tag = "R8";
      wr(3'd0, 32'hFFFF_FFF0);
      ticks(3); idle();
      snap = count_o;
      check64("R9 lower carry into upper", snap, 64'h3_0000_01B9);
      cyc(1, 0, 0, 0, 1, 3'd3);
      cyc(1, 0, 0, 0, 1, 3'd4);
      check64("R8 lower word", {32'd0, rd_data}, {32'd0, snap[31:0]});
      idle();
      check64("R8 captured upper", {32'd0, rd_data}, {32'd0, snap[63:32]});

      tag = "R9";
      do_reset();
      wr(3'd1, 32'h0000_0063); wr(3'd2, 32'd1);
      ticks(2); idle();
      check64("R9 borrow wraps 64 bits", count_o, 64'hFFFF_FFFF_FFFF_FFFF);
      cyc(0, 0, 0, 0, 1, 3'd3); cyc(0, 0, 0, 0, 1, 3'd4);
      check64("R9 lower after wrap", {32'd0, rd_data}, 64'hFFFF_FFFF);
      idle();
      check64("R9 upper after wrap", {32'd0, rd_data}, 64'hFFFF_FFFF);

      tag = "R2";
      wr(3'd2, 32'd0);
      ticks(3); idle();
      check64("R2 frozen when run cleared", count_o, 64'hFFFF_FFFF_FFFF_FFFF);
      wr(3'd2, 32'd1);
      ticks(1); idle();
      check64("R2 accumulator resumed", count_o, 64'hFFFF_FFFF_FFFF_FFFE);

      tag = "R7";
      cyc(0, 0, 0, 0, 1, 3'd1); idle();
      check64("R7 trim readback", {32'd0, rd_data}, 64'h63);
      cyc(0, 0, 0, 0, 1, 3'd2); idle();
      check64("R7 run readback", {32'd0, rd_data}, 64'd1);
      cyc(0, 0, 0, 0, 1, 3'd6); idle();
      check64("R7 unmapped reads zero", {32'd0, rd_data}, 64'd0);
      idle(); idle();
      check64("R7 rd_data holds", {32'd0, rd_data}, 64'd0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule